// File: doc/BRIEF.md
# Gated 13-bit Counter/Timer Channel

This block is one timer channel of a microcontroller peripheral, fixed in its 13-bit mode. A 13-bit count register goes up by one on a selected event. The event can be every system clock cycle, a prescaled clock-enable pulse supplied from outside, or a falling edge on an external count pin. A run bit starts and stops counting. When gate mode is on, counting is further qualified by an external gate pin whose active level is programmable. This lets software measure the width of a pulse on the gate pin.

Software reaches the channel through a byte-wide port. Address 0 is the low count byte, address 1 is the high count byte and address 2 is the control byte. Reads are combinational on the same address lines. When the count passes from its all-ones value to zero, a sticky overflow flag is set. The interrupt output is that flag qualified by an enable bit. Software clears the flag by writing it to 0 or by pulsing an acknowledge input.

The asynchronous reset input is released into the clock domain through a short synchronizer. Both external pins are synchronized before use.

Top module: `ct13_timer`

## Requirements
- R1: The high byte (address 1) reads count[12:5] and the low byte (address 0) reads count[4:0] in bits 4..0. Bits 7..5 of the low byte are not part of the count and have no defined value.
- R2: A write to address 0 loads only count[4:0], and a write to address 1 loads only count[12:5]. The other byte is unchanged. A count write in the same cycle as an increment wins, and no increment happens in that cycle.
- R3: When the count goes from 0x1FFF to 0x0000, the overflow flag is set. The flag reads as bit 6 of the control byte at address 2.
- R4: The output irq is high exactly when the overflow flag is set and the interrupt enable is set. The interrupt enable is control bit 5.
- R5: The overflow flag is cleared by writing 0 to control bit 6 or by a one-cycle pulse on irq_ack. Writing 1 to bit 6 leaves the flag unchanged.
- R6: When the source select is 1 (control bit 3), each high-to-low transition on ext_cnt adds exactly one to the count. Rising edges, the clock select and presc_tick have no effect in this setting.
- R7: When the source select is 0, the clock select (control bit 4) chooses the increment source. A value of 1 adds one every cycle. A value of 0 adds one on each cycle in which presc_tick is high.
- R8: The count advances only when the run bit (control bit 0) is 1 and either the gate-mode bit (control bit 1) is 0 or ext_gate equals the gate polarity bit (control bit 2). In every other case the count holds.
- R9: Setting the run bit keeps the loaded count. Counting continues from the value software wrote.
- R10: After reset, the count, all control bits, the overflow flag and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write (0 low, 1 high, 2 control) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| presc_tick | input | 1 | Prescaled clock-enable pulse |
| ext_cnt | input | 1 | External count pin, asynchronous |
| ext_gate | input | 1 | External gate pin, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default build: a 13-bit count split as 5 low bits and 8 high bits, with two synchronizer stages. With only 8192 count values, every value is written byte by byte and read back, and the run-length checks sweep several start points. The run bit, gate mode, gate polarity and gate level are swept across all sixteen combinations. Each expected count is computed from the number of enabled edges. The small width also puts the 0x1FFF-to-zero rollover within a few cycles of a loaded start value, so the flag set, enable and clear paths are checked directly.

// File: rtl/ct13_pkg.sv
package ct13_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ADDR_LO  = 2'd0,
    ADDR_HI  = 2'd1,
    ADDR_CTL = 2'd2
  } reg_addr_e;

  // control byte bits 5..0; flag sits at bit 6
  typedef struct packed {
    logic ie;         // bit 5
    logic clk_sel;    // bit 4
    logic cnt_src;    // bit 3
    logic gate_pol;   // bit 2
    logic gate_mode;  // bit 1
    logic run;        // bit 0
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int FLAG_BIT = CTRL_W;
endpackage

// File: rtl/ct13_rst_sync.sv
module ct13_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/ct13_input_cond.sv
module ct13_input_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_pin,
  input  logic gate_pin,
  input  logic gate_pol,
  output logic fall_o,
  output logic gate_active_o
);
  logic [STAGES-1:0] cnt_sync_q, cnt_sync_d;
  logic [STAGES-1:0] gate_sync_q, gate_sync_d;
  logic              cnt_prev_q;

  always_comb begin
    cnt_sync_d  = {cnt_sync_q[STAGES-2:0], cnt_pin};
    gate_sync_d = {gate_sync_q[STAGES-2:0], gate_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_sync_q  <= '0;
      gate_sync_q <= '0;
      cnt_prev_q  <= 1'b0;
    end else begin
      cnt_sync_q  <= cnt_sync_d;
      gate_sync_q <= gate_sync_d;
      cnt_prev_q  <= cnt_sync_q[STAGES-1];
    end
  end

  assign fall_o        = cnt_prev_q & ~cnt_sync_q[STAGES-1];
  assign gate_active_o = (gate_sync_q[STAGES-1] == gate_pol);
endmodule

// File: rtl/ct13_count.sv
module ct13_count #(
  parameter int CNT_W  = 13,
  parameter int LO_W   = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              inc,
  output logic [CNT_W-1:0]  count,
  output logic              wrap_o
);
  localparam int HI_W = CNT_W - LO_W;

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             any_wr;

  assign any_wr = wr_lo | wr_hi;
  assign cnt_en = any_wr | inc;
  assign wrap_o = inc & ~any_wr & (&count);

  always_comb begin
    cnt_d = count;
    if (any_wr) begin
      if (wr_lo) cnt_d[LO_W-1:0]     = wr_data[LO_W-1:0];
      if (wr_hi) cnt_d[CNT_W-1:LO_W] = wr_data[HI_W-1:0];
    end else if (inc) begin
      cnt_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end
endmodule

// File: rtl/ct13_ctrl.sv
module ct13_ctrl
  import ct13_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic [CTRL_W:0]   wr_bits,
  input  logic              irq_ack,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic              flag
);
  ctrl_t ctrl_d;
  logic  flag_d;

  always_comb begin
    ctrl_d = wr_ctl ? ctrl_t'(wr_bits[CTRL_W-1:0]) : ctrl;
  end

  always_comb begin
    flag_d = flag;
    if (wrap)                                 flag_d = 1'b1;
    else if (irq_ack)                         flag_d = 1'b0;
    else if (wr_ctl && !wr_bits[FLAG_BIT])    flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      flag <= 1'b0;
    end else begin
      ctrl <= ctrl_d;
      flag <= flag_d;
    end
  end
endmodule

// File: rtl/ct13_timer.sv
module ct13_timer
  import ct13_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int LO_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              presc_tick,
  input  logic              ext_cnt,
  input  logic              ext_gate,
  input  logic              irq_ack,
  output logic              irq
);
  localparam int HI_W = CNT_W - LO_W;

  logic             rst_n_s;
  logic             fall;
  logic             gate_active;
  logic             tick;
  logic             inc;
  logic             wrap;
  logic             flag;
  logic [CNT_W-1:0] count;
  ctrl_t            ctrl;
  logic             wr_lo, wr_hi, wr_ctl;
  logic             unused_wr_msb;

  assign unused_wr_msb = wr_data[BYTE_W-1];

  ct13_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s)
  );

  ct13_input_cond #(.STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst_n(rst_n_s), .cnt_pin(ext_cnt), .gate_pin(ext_gate),
    .gate_pol(ctrl.gate_pol), .fall_o(fall), .gate_active_o(gate_active)
  );

  assign wr_lo  = wr_en && (addr == ADDR_LO);
  assign wr_hi  = wr_en && (addr == ADDR_HI);
  assign wr_ctl = wr_en && (addr == ADDR_CTL);

  always_comb begin
    if (ctrl.cnt_src)      tick = fall;
    else if (ctrl.clk_sel) tick = 1'b1;
    else                   tick = presc_tick;
  end

  assign inc = ctrl.run & (~ctrl.gate_mode | gate_active) & tick;

  ct13_count #(.CNT_W(CNT_W), .LO_W(LO_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .inc(inc), .count(count), .wrap_o(wrap)
  );

  ct13_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n_s), .wr_ctl(wr_ctl),
    .wr_bits(wr_data[CTRL_W:0]), .irq_ack(irq_ack), .wrap(wrap),
    .ctrl(ctrl), .flag(flag)
  );

  always_comb begin
    rd_data = '0;
    unique case (addr)
      ADDR_LO:  rd_data[LO_W-1:0] = count[LO_W-1:0];
      ADDR_HI:  rd_data[HI_W-1:0] = count[CNT_W-1:LO_W];
      ADDR_CTL: rd_data[CTRL_W:0] = {flag, ctrl};
      default:  rd_data = '0;
    endcase
  end

  assign irq = flag & ctrl.ie;
endmodule

// File: rtl/ct13_timer_chk.sv
module ct13_timer_chk #(
  parameter int CNT_W = 13,
  parameter int LO_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [7:0]       wr_data,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             run,
  input logic             inc,
  input logic             irq_ack
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (addr == 2'd0 || addr == 2'd1);

  a_r2_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (count[LO_W-1:0] == $past(wr_data[LO_W-1:0]))
      && (count[CNT_W-1:LO_W] == $past(count[CNT_W-1:LO_W])));

  a_r2_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (count[CNT_W-1:LO_W] == $past(wr_data[CNT_W-LO_W-1:0]))
      && (count[LO_W-1:0] == $past(count[LO_W-1:0])));

  a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (&count) && !cnt_wr) |=> (flag && count == '0));

  a_r3_flag_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(&count));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(inc && (&count))) |=> !flag);

  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));
endmodule

bind ct13_timer ct13_timer_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .count(count), .flag(flag), .run(ctrl.run), .inc(inc), .irq_ack(irq_ack)
);

// File: tb/ct13_timer_bench.sv
module ct13_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       presc_tick = 1'b0;
  logic       ext_cnt = 1'b1;
  logic       ext_gate = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  ct13_timer u_ct13_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .presc_tick(presc_tick), .ext_cnt(ext_cnt),
    .ext_gate(ext_gate), .irq_ack(irq_ack), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rd_data;
  endtask

  task automatic rd_count(output int v);
    logic [7:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    v = {hi, lo[4:0]};
  endtask

  task automatic load(input int v);
    wr(2'd0, {3'b111, v[4:0]}); wr(2'd1, v[12:5]);
  endtask

  // bits: 0 run, 1 gate mode, 2 gate polarity, 3 source, 4 clk select, 5 ie, 6 flag
  function automatic logic [7:0] cb(input logic run, gm, gp, src, cs, ie, keep);
    return {1'b0, keep, ie, cs, src, gp, gm, run};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    logic [7:0] b;
    idle(5); rst_n = 1'b1; idle(4);

    // R10 reset state
    rd_count(v);   check("R10 count", v, 0);
    rd(2'd2, b);   check("R10 control", b, 0);
    check("R10 irq", irq, 0);

    // R1 R2 every count value, byte by byte, junk in low bits 7..5
    for (int x = 0; x < 8192; x++) begin
      load(x);
      rd_count(v);
      check("R1 readback", v, x);
    end
    wr(2'd1, 8'h5A); rd_count(v); check("R2 high only", v, {8'h5A, 5'h1F});
    wr(2'd0, 8'h03); rd_count(v); check("R2 low only", v, {8'h5A, 5'h03});

    // R9 R7 system clock runs: m idle cycles gives m+2 increments
    for (int m = 0; m < 8; m++) begin
      load(16'h0123 + 37 * m);
      wr(2'd2, cb(1, 0, 0, 0, 1, 0, 1));
      idle(m);
      wr(2'd2, cb(0, 0, 0, 0, 1, 0, 1));
      rd_count(v);
      check("R9 keeps loaded start", v, 16'h0123 + 37 * m + m + 2);
    end

    // R7 prescaled ticks only
    load(0);
    wr(2'd2, cb(1, 0, 0, 0, 0, 0, 1));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); presc_tick = 1'b1;
      @(negedge clk); presc_tick = 1'b0;
      @(negedge clk);
    end
    wr(2'd2, cb(0, 0, 0, 0, 0, 0, 1));
    rd_count(v); check("R7 prescaled count", v, 5);

    // R8 run x gate mode x polarity x gate level
    for (int c = 0; c < 16; c++) begin
      logic r, gm, gp, lvl;
      {r, gm, gp, lvl} = c[3:0];
      load(0);
      ext_gate = lvl; idle(4);
      wr(2'd2, cb(r, gm, gp, 0, 1, 0, 1));
      idle(3);
      wr(2'd2, cb(0, gm, gp, 0, 1, 0, 1));
      rd_count(v);
      check("R8 gating", v, (r && (!gm || lvl == gp)) ? 5 : 0);
    end

    // R6 external falling edges; clk select and presc_tick set but ignored
    ext_cnt = 1'b1; idle(4);
    load(0);
    presc_tick = 1'b1;
    wr(2'd2, cb(1, 0, 0, 1, 1, 0, 1));
    for (int k = 0; k < 6; k++) begin
      ext_cnt = 1'b0; idle(4);
      ext_cnt = 1'b1; idle(4);
    end
    rd_count(v); check("R6 one per falling edge", v, 6);
    wr(2'd2, cb(0, 0, 0, 1, 1, 0, 1));
    presc_tick = 1'b0;

    // R3 no flag short of rollover
    load(16'h1FF0);
    wr(2'd2, cb(1, 0, 0, 0, 1, 0, 1));
    wr(2'd2, cb(0, 0, 0, 0, 1, 0, 1));
    rd_count(v); check("R3 near top", v, 16'h1FF2);
    rd(2'd2, b);  check("R3 flag clear", b[6], 0);

    // R3 R4 rollover with interrupt disabled
    load(16'h1FFE);
    wr(2'd2, cb(1, 0, 0, 0, 1, 0, 1));
    idle(4);
    wr(2'd2, cb(0, 0, 0, 0, 1, 0, 1));
    rd_count(v); check("R3 wrapped count", v, 4);
    rd(2'd2, b);  check("R3 flag set", b[6], 1);
    check("R4 irq masked", irq, 0);
    wr(2'd2, cb(0, 0, 0, 0, 1, 1, 1));
    check("R4 irq enabled", irq, 1);
    check("R5 write one keeps flag", rd_data[6], 1);
    wr(2'd2, cb(0, 0, 0, 0, 1, 1, 0));
    rd(2'd2, b);  check("R5 write zero clears", b[6], 0);
    check("R4 irq after clear", irq, 0);

    // R5 acknowledge
    load(16'h1FFF);
    wr(2'd2, cb(1, 0, 0, 0, 1, 1, 1));
    wr(2'd2, cb(0, 0, 0, 0, 1, 1, 1));
    rd_count(v); check("R3 from all ones", v, 1);
    check("R4 irq raised", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R5 ack clears irq", irq, 0);
    rd(2'd2, b);  check("R5 ack clears flag", b[6], 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule